// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver with End-of-Service Commands

This block keeps the pending, in-service and priority-base state for a small set of interrupt inputs. It decides which pending request may interrupt the processor. Each request is captured on a rising edge or followed as a level. It is then screened by an externally held mask and ranked on a ring whose lowest-priority level can move. In the default nested discipline, a request is raised only when it outranks everything already being serviced.

The surrounding bus logic decodes software writes into a 3-bit command code with a 3-bit level field, and supplies the mask, trigger mode, auto-completion mode and special-mask mode as plain inputs. The acknowledge sequencer watches `int_req` and `win_lvl`, and it pulses `take` when the processor accepts the interrupt. That pulse moves the winner from pending to in service. Completion commands later clear in-service bits and can rotate the ring. The pending and in-service vectors, the highest in-service level and the current lowest-priority level are all brought out for readback.

Top module: `irq_prio_eoi`

## Requirements
- R1: After reset, `irr_q`, `isr_q`, `int_req`, `isr_busy` and `aeoi_rot` are 0, and `low_lvl` is 7, so level 0 has the highest priority.
- R2: With `level_mode`=0, a 0-to-1 change on `irq_in[k]` sets `irr_q[k]` one clock later. An input that stays high after its bit is taken does not set the bit again.
- R3: With `level_mode`=1, `irr_q` equals `irq_in` as sampled on the previous clock.
- R4: Priority runs from level (`low_lvl`+1) mod 8 upward around the ring. Among the unmasked pending levels that are not in service, the highest-ranked one appears on `win_lvl`, with `int_req`=1, one clock after it becomes eligible.
- R5: A level whose `mask_in` bit is 1 is never presented. With every level pending, `int_req` is 0 exactly when the mask is all ones.
- R6: With `spec_mask`=0, a pending level is held off while any level of equal or higher rank is in service. A strictly higher-ranked level still raises `int_req`.
- R7: `take` while `int_req`=1 clears `int_req` on the next clock and moves `win_lvl` from `irr_q` (edge mode) into `isr_q`. With `auto_eoi`=1, `isr_q` is left unchanged.
- R8: Command code 1 clears the in-service bit of the highest-ranked in-service level. Code 5 does the same and also sets `low_lvl` to the cleared level.
- R9: Command code 3 clears `isr_q[cmd_lvl]`. Code 7 does the same and also sets `low_lvl` to `cmd_lvl`.
- R10: After a rotating completion (code 5 or 7), `low_lvl` equals the level that was cleared.
- R11: Command code 6 sets `low_lvl` to `cmd_lvl` and leaves `isr_q` unchanged. Code 2 changes nothing.
- R12: Code 4 sets `aeoi_rot` and code 0 clears it. While `auto_eoi`=1 and `aeoi_rot`=1, a take sets `low_lvl` to the taken level.
- R13: With `spec_mask`=1, any unmasked pending level that is not itself in service is presented, whatever else is in service.
- R14: `isr_top` gives the highest-ranked set bit of `isr_q`, and `isr_busy` is 1 whenever `isr_q` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines |
| mask_in | input | 8 | Per-level mask, 1 blocks the level |
| level_mode | input | 1 | 1 = level capture, 0 = rising-edge capture |
| auto_eoi | input | 1 | 1 = a take does not mark the level in service |
| spec_mask | input | 1 | 1 = in-service state does not hold off requests |
| take | input | 1 | Acceptance pulse for the presented level |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_lvl | input | 3 | Level operand of the command |
| int_req | output | 1 | Registered interrupt request to the processor |
| win_lvl | output | 3 | Level being presented |
| irr_q | output | 8 | Pending vector |
| isr_q | output | 8 | In-service vector |
| isr_top | output | 3 | Highest-ranked in-service level |
| isr_busy | output | 1 | Some level is in service |
| low_lvl | output | 3 | Current lowest-priority level |
| aeoi_rot | output | 1 | Rotate-on-automatic-completion flag |

## Verification
The bench builds the block with its default of eight levels, which keeps the whole state space small enough to sweep. It visits every priority base, and for each base it tries every pair of levels in both arrival orders, which exercises nesting, preemption and both completion forms. It applies all 256 mask patterns while every level is held pending. Rotation, auto-completion and special-mask mode are each exercised for every level or through a directed sequence.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    OP_AROT_OFF = 3'd0,
    OP_EOI_TOP  = 3'd1,
    OP_NOP      = 3'd2,
    OP_EOI_AT   = 3'd3,
    OP_AROT_ON  = 3'd4,
    OP_ROT_TOP  = 3'd5,
    OP_SET_LOW  = 3'd6,
    OP_ROT_AT   = 3'd7
  } op_e;
endpackage

// File: rtl/req_capture.sv
module req_capture #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          level_mode,
  input  logic          clr_en,
  input  logic [LW-1:0] clr_lvl,
  output logic [N-1:0]  irr
);
  logic [N-1:0] prev;
  logic [N-1:0] rise;
  logic [N-1:0] clr_mask;

  always_comb begin
    rise     = irq_in & ~prev;
    clr_mask = clr_en ? ({{(N-1){1'b0}}, 1'b1} << clr_lvl) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq_in;
      if (level_mode) irr <= irq_in;
      else            irr <= (irr & ~clr_mask) | rise;
    end
  end

  assert_level_follow_R3: assert property (@(posedge clk) disable iff (rst)
    level_mode |=> (irr == $past(irq_in)));

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && (|rise)) |=> ((irr & $past(rise)) == $past(rise)));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] low,
  output logic          hit,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  int             sh;

  always_comb begin
    sh   = (int'(low) + 1) % N;
    dbl  = {vec, vec} >> sh;
    rot  = dbl[N-1:0];
    hit  = |rot;
    rank = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) rank = LW'(i);
    end
    lvl = LW'((int'(rank) + sh) % N);
  end

  always_comb begin
    if (hit) assert_pick_is_set_R4: assert (vec[lvl]);
  end
endmodule

// File: rtl/svc_ctrl.sv
module svc_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_en,
  input  logic [LW-1:0] take_lvl,
  input  logic          auto_eoi,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_lvl,
  input  logic          top_hit,
  input  logic [LW-1:0] top_lvl,
  output logic [N-1:0]  isr,
  output logic [LW-1:0] low_lvl,
  output logic          aeoi_rot
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  op_e           op;
  logic [N-1:0]  set_m;
  logic [N-1:0]  clr_m;
  logic [LW-1:0] low_n;
  logic          arot_n;

  always_comb begin
    op     = op_e'(cmd_op);
    set_m  = (take_en && !auto_eoi) ? (ONE << take_lvl) : '0;
    clr_m  = '0;
    low_n  = low_lvl;
    arot_n = aeoi_rot;
    if (take_en && auto_eoi && aeoi_rot) low_n = take_lvl;
    if (cmd_valid) begin
      case (op)
        OP_AROT_OFF: arot_n = 1'b0;
        OP_AROT_ON:  arot_n = 1'b1;
        OP_EOI_TOP:  if (top_hit) clr_m = ONE << top_lvl;
        OP_ROT_TOP: begin
          if (top_hit) begin
            clr_m = ONE << top_lvl;
            low_n = top_lvl;
          end
        end
        OP_EOI_AT:   clr_m = ONE << cmd_lvl;
        OP_ROT_AT: begin
          clr_m = ONE << cmd_lvl;
          low_n = cmd_lvl;
        end
        OP_SET_LOW:  low_n = cmd_lvl;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr      <= '0;
      low_lvl  <= LW'(N - 1);
      aeoi_rot <= 1'b0;
    end else begin
      isr      <= (isr & ~clr_m) | set_m;
      low_lvl  <= low_n;
      aeoi_rot <= arot_n;
    end
  end

  assert_take_sets_isr_R7: assert property (@(posedge clk) disable iff (rst)
    (take_en && !auto_eoi && !cmd_valid) |=> isr[$past(take_lvl)]);

  assert_eoi_top_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1 && top_hit && !take_en)
      |=> ($countones(isr) == $countones($past(isr)) - 1));

  assert_eoi_at_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd3 && !take_en) |=> !isr[$past(cmd_lvl)]);

  assert_set_low_keeps_isr_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd6 && !take_en)
      |=> ($stable(isr) && low_lvl == $past(cmd_lvl)));
endmodule

// File: rtl/irq_prio_eoi.sv
module irq_prio_eoi #(
  parameter int N_LVL = 8,
  localparam int LW = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LVL-1:0] irq_in,
  input  logic [N_LVL-1:0] mask_in,
  input  logic             level_mode,
  input  logic             auto_eoi,
  input  logic             spec_mask,
  input  logic             take,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [LW-1:0]    cmd_lvl,
  output logic             int_req,
  output logic [LW-1:0]    win_lvl,
  output logic [N_LVL-1:0] irr_q,
  output logic [N_LVL-1:0] isr_q,
  output logic [LW-1:0]    isr_top,
  output logic             isr_busy,
  output logic [LW-1:0]    low_lvl,
  output logic             aeoi_rot
);
  logic             take_en;
  logic [N_LVL-1:0] cand;
  logic             cand_hit, isr_hit, grant_ok;
  logic [LW-1:0]    cand_lvl, cand_rank, isr_lvl, isr_rank;
  logic [N_LVL-1:0] mask_d;

  assign take_en = take && int_req;

  req_capture #(.N(N_LVL), .LW(LW)) u_cap (
    .clk(clk), .rst(rst), .irq_in(irq_in), .level_mode(level_mode),
    .clr_en(take_en), .clr_lvl(win_lvl), .irr(irr_q)
  );

  svc_ctrl #(.N(N_LVL), .LW(LW)) u_svc (
    .clk(clk), .rst(rst), .take_en(take_en), .take_lvl(win_lvl),
    .auto_eoi(auto_eoi), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_lvl(cmd_lvl), .top_hit(isr_hit), .top_lvl(isr_lvl),
    .isr(isr_q), .low_lvl(low_lvl), .aeoi_rot(aeoi_rot)
  );

  assign cand = irr_q & ~mask_in & ~isr_q;

  prio_pick #(.N(N_LVL), .LW(LW)) u_pick_req (
    .vec(cand), .low(low_lvl), .hit(cand_hit), .lvl(cand_lvl), .rank(cand_rank)
  );

  prio_pick #(.N(N_LVL), .LW(LW)) u_pick_svc (
    .vec(isr_q), .low(low_lvl), .hit(isr_hit), .lvl(isr_lvl), .rank(isr_rank)
  );

  assign grant_ok = cand_hit && (spec_mask || !isr_hit || (cand_rank < isr_rank));
  assign isr_top  = isr_lvl;
  assign isr_busy = isr_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req <= 1'b0;
      win_lvl <= '0;
      mask_d  <= '0;
    end else begin
      mask_d  <= mask_in;
      int_req <= grant_ok && !take_en;
      if (grant_ok) win_lvl <= cand_lvl;
    end
  end

  assert_take_drops_req_R7: assert property (@(posedge clk) disable iff (rst)
    (take && int_req) |=> !int_req);

  assert_req_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
    int_req |-> !mask_d[win_lvl]);
endmodule

// File: tb/sim_irq_prio_eoi.sv
module sim_irq_prio_eoi;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq = '0, mask = '0;
  logic       level_mode = 0, aeoi = 0, smm = 0, take = 0, cmd_v = 0;
  logic [2:0] cmd_op = '0, cmd_lvl = '0;
  logic       int_req, isr_busy, aeoi_rot;
  logic [2:0] win_lvl, isr_top, low_lvl;
  logic [7:0] irr_q, isr_q;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  irq_prio_eoi u0 (
    .clk(clk), .rst(rst), .irq_in(irq), .mask_in(mask), .level_mode(level_mode),
    .auto_eoi(aeoi), .spec_mask(smm), .take(take), .cmd_valid(cmd_v),
    .cmd_op(cmd_op), .cmd_lvl(cmd_lvl), .int_req(int_req), .win_lvl(win_lvl),
    .irr_q(irr_q), .isr_q(isr_q), .isr_top(isr_top), .isr_busy(isr_busy),
    .low_lvl(low_lvl), .aeoi_rot(aeoi_rot)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1; irq = '0; mask = '0; level_mode = 0; aeoi = 0; smm = 0;
    take = 0; cmd_v = 0;
    step(2);
    rst = 0;
    step(1);
  endtask

  task automatic send(int op, int lvl);
    cmd_v = 1; cmd_op = op[2:0]; cmd_lvl = lvl[2:0];
    step(1);
    cmd_v = 0;
  endtask

  task automatic grab;
    take = 1;
    step(1);
    take = 0;
  endtask

  function automatic int rk(int l, int b);
    return (l - b + 15) % 8;
  endfunction

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_up();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 int_req", int'(int_req), 0);
    chk("R1 irr", int'(irr_q), 0);
    chk("R1 isr", int'(isr_q), 0);
    chk("R1 busy", int'(isr_busy), 0);
    chk("R1 aeoi_rot", int'(aeoi_rot), 0);
    chk("R1 low", int'(low_lvl), 7);

    // R2 edge capture
    irq = 8'h04; step(1);
    chk("R2 irr set", int'(irr_q), 4);
    step(1);
    chk("R4 req", int'(int_req), 1);
    chk("R4 win", int'(win_lvl), 2);
    grab();
    chk("R7 irr cleared", int'(irr_q), 0);
    chk("R7 isr", int'(isr_q), 4);
    chk("R7 req drop", int'(int_req), 0);
    step(2);
    chk("R2 held high no reset", int'(irr_q), 0);
    send(1, 0);
    irq = 0; step(1);
    irq = 8'h04; step(1);
    chk("R2 new edge", int'(irr_q), 4);

    // Pair sweep: priority order, nesting, non-specific completion
    do_reset();
    for (int b = 0; b < 8; b++) begin
      send(6, b);
      chk("R11 low set", int'(low_lvl), b);
      for (int i = 0; i < 8; i++) begin
        for (int j = i + 1; j < 8; j++) begin
          int w, o;
          w = (rk(i, b) < rk(j, b)) ? i : j;
          o = (w == i) ? j : i;
          irq = 8'(1 << i) | 8'(1 << j);
          step(2);
          chk("R4 pair req", int'(int_req), 1);
          chk("R4 pair win", int'(win_lvl), w);
          grab();
          chk("R7 pair isr", int'(isr_q), 1 << w);
          chk("R14 top", int'(isr_top), w);
          chk("R14 busy", int'(isr_busy), 1);
          step(1);
          chk("R6 lower held", int'(int_req), 0);
          send(1, 0);
          chk("R8 clear top", int'(isr_q), 0);
          step(1);
          chk("R6 released", int'(int_req), 1);
          chk("R4 second win", int'(win_lvl), o);
          grab();
          send(1, 0);
          irq = 0; step(1);
        end
      end
    end

    // Preemption by a higher level, then both completion forms
    do_reset();
    for (int b = 0; b < 8; b++) begin
      send(6, b);
      for (int a = 0; a < 8; a++) begin
        for (int c = 0; c < 8; c++) begin
          if (rk(a, b) < rk(c, b)) begin
            irq = 8'(1 << c); step(2);
            grab();
            irq = irq | 8'(1 << a); step(2);
            chk("R6 higher passes", int'(int_req), 1);
            chk("R6 higher win", int'(win_lvl), a);
            grab();
            chk("R7 two in service", int'(isr_q), (1 << a) | (1 << c));
            chk("R14 top of two", int'(isr_top), a);
            send(1, 0);
            chk("R8 clears highest", int'(isr_q), 1 << c);
            send(3, c);
            chk("R9 specific clear", int'(isr_q), 0);
            irq = 0; step(1);
          end
        end
      end
    end

    // R11 set-priority and no-op leave service state; R10 rotation
    do_reset();
    irq = 8'h08; step(2);
    grab();
    send(6, 5);
    chk("R11 isr kept", int'(isr_q), 8);
    chk("R11 low", int'(low_lvl), 5);
    send(2, 1);
    chk("R11 nop isr", int'(isr_q), 8);
    chk("R11 nop low", int'(low_lvl), 5);
    send(5, 0);
    chk("R8 rotate top clear", int'(isr_q), 0);
    chk("R10 rotate top low", int'(low_lvl), 3);
    irq = 0; step(1);
    for (int l = 0; l < 8; l++) begin
      irq = 8'(1 << l); step(2);
      grab();
      send(7, l);
      chk("R9 rotate at clear", int'(isr_q), 0);
      chk("R10 rotate at low", int'(low_lvl), l);
      irq = 0; step(1);
    end

    // R12 automatic completion
    do_reset();
    aeoi = 1;
    irq = 8'h10; step(2);
    grab();
    chk("R7 auto no isr", int'(isr_q), 0);
    chk("R12 no rotate", int'(low_lvl), 7);
    irq = 0; step(1);
    send(4, 0);
    chk("R12 flag on", int'(aeoi_rot), 1);
    irq = 8'h10; step(2);
    grab();
    chk("R12 rotated", int'(low_lvl), 4);
    chk("R12 isr", int'(isr_q), 0);
    send(0, 0);
    chk("R12 flag off", int'(aeoi_rot), 0);
    irq = 0; step(1);
    irq = 8'h40; step(2);
    grab();
    chk("R12 no rotate after off", int'(low_lvl), 4);
    aeoi = 0; irq = 0;

    // R13 special mask mode
    do_reset();
    irq = 8'h20; step(2);
    grab();
    irq = 8'h60; step(2);
    chk("R6 lower blocked", int'(int_req), 0);
    smm = 1; step(1);
    chk("R13 req", int'(int_req), 1);
    chk("R13 win", int'(win_lvl), 6);
    grab();
    chk("R13 isr", int'(isr_q), 8'h60);
    smm = 0; irq = 0;

    // R3 level capture and R5 mask sweep
    do_reset();
    level_mode = 1;
    irq = 8'hFF; step(1);
    chk("R3 level all", int'(irr_q), 8'hFF);
    for (int m = 0; m < 256; m++) begin
      int ew;
      mask = 8'(m); step(1);
      ew = 0;
      for (int k = 7; k >= 0; k--) if (((m >> k) & 1) == 0) ew = k;
      chk("R5 mask req", int'(int_req), (m != 255) ? 1 : 0);
      if (m != 255) chk("R5 mask win", int'(win_lvl), ew);
    end
    irq = 8'h5A; step(1);
    chk("R3 level pattern", int'(irr_q), 8'h5A);
    irq = 0; step(1);
    chk("R3 level drop", int'(irr_q), 0);

    finish_up();
  end
endmodule